// File: doc/BRIEF.md
# Nonvolatile Memory Write Cycle Qualifier

This block sits behind the synchronously sampled control pins of a byte-wide nonvolatile memory array (active-low chip select, write enable and output enable, plus address and data) and decides when the pins describe a genuine write. A write exists only while both chip select and write enable are low together. The address is taken in the first clock sample where both are seen low, which is the later of the two falling strobes. The data is taken in the first sample where either strobe is seen high again, which is the earlier of the two rising strobes.

On top of that pairing rule the block rejects short low pulses as noise. It discards any cycle during which output enable is low or the supply is not good. It also keeps writes locked out until a digital supply-good bit has stayed high for a programmable number of cycles. Every accepted cycle leaves the block as a single-cycle strobe that carries the captured address and data towards a page write controller.

Top module: `nvm_write_qualifier`

## Requirements
- R1: After reset `wr_stb` is low and `wr_addr` and `wr_data` are zero.
- R2: A write is considered only while `cs_n` and `we_n` are both low in the same clock sample. One strobe held low by itself never produces `wr_stb`.
- R3: `wr_addr` carries the value of `addr` in the first sample of the low pulse, the first sample in which both strobes are low. Later changes to `addr` during the pulse have no effect.
- R4: `wr_data` carries the value of `din` in the first sample after the pulse in which either strobe is high. `wr_stb` is high for exactly one cycle, visible right after that sample. `wr_addr` and `wr_data` change only together with `wr_stb`.
- R5: A low pulse lasting fewer than `MIN_LOW_CYC` consecutive samples is discarded. A pulse of exactly `MIN_LOW_CYC` samples is accepted.
- R6: If `oe_n` is low in any sample of the low pulse, the cycle is discarded and no strobe is issued.
- R7: While `supply_ok` is low no write is accepted. After it rises, writes stay locked until it has been high for `PWR_DLY_CYC` consecutive samples.
- R8: A drop of `supply_ok` during an otherwise valid low pulse discards that cycle.
- R9: The result does not depend on which strobe falls first or which strobe rises first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low, synchronous sample |
| we_n | input | 1 | Write enable, active low, synchronous sample |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| addr | input | ADDR_W | Address bus sample |
| din | input | DATA_W | Data bus sample |
| supply_ok | input | 1 | Supply comparator output, high when above threshold |
| wr_stb | output | 1 | One-cycle strobe for an accepted write |
| wr_addr | output | ADDR_W | Address captured for the last accepted write |
| wr_data | output | DATA_W | Data captured for the last accepted write |

## Verification
The embedded properties watch, in every cycle, that a strobe never lasts two cycles and that it always follows a sample with both strobes low and then one with a strobe high. They also check that it never comes from a sample with output enable low or the supply locked, that an aborted cycle stays silent, and that the captured fields hold between strobes. Only the bench scenarios can show that the exact address and data values come from the right edges, in both strobe orderings. The bench scenarios also cover the glitch limit at its boundary, and the lockout after a supply dip releasing only after the full delay.

// File: rtl/nwq_pkg.sv
`timescale 1ns/1ps
package nwq_pkg;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'd0,
    QS_OPEN  = 2'd1,
    QS_SPOIL = 2'd2
  } qual_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/nwq_power_lockout.sv
`timescale 1ns/1ps
module nwq_power_lockout #(
  parameter int unsigned PWR_DLY_CYC = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic write_ok
);

  localparam int unsigned CW = nwq_pkg::cnt_width(PWR_DLY_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(PWR_DLY_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !supply_ok || (cnt_q != LIMIT);
    cnt_d  = supply_ok ? (cnt_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign write_ok = supply_ok && (cnt_q == LIMIT);

  AST_LOCK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R7

  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_ok) |-> $past(supply_ok)); // R7

endmodule

// File: rtl/nwq_low_filter.sv
`timescale 1ns/1ps
module nwq_low_filter #(
  parameter int unsigned MIN_LOW_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_both,
  output logic long_enough
);

  localparam int unsigned CW = nwq_pkg::cnt_width(MIN_LOW_CYC);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (!low_both)         cnt_d = '0;
    else if (cnt_q == LIM) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign long_enough = (cnt_q == LIM);

  AST_FILTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R5

  AST_FILTER_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_enough) |-> $past(low_both)); // R5

endmodule

// File: rtl/nwq_cycle_ctl.sv
`timescale 1ns/1ps
module nwq_cycle_ctl #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_both,
  input  logic              oe_n,
  input  logic              write_ok,
  input  logic              long_enough,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  import nwq_pkg::*;

  qual_state_e       st_q, st_d;
  logic [ADDR_W-1:0] cand_q, cand_d;
  logic              stb_q, stb_d;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              inhibit;
  logic              out_en;

  always_comb begin
    inhibit = !oe_n || !write_ok;
    st_d    = st_q;
    cand_d  = cand_q;
    stb_d   = 1'b0;
    case (st_q)
      QS_IDLE: begin
        if (low_both) begin
          cand_d = addr;
          st_d   = inhibit ? QS_SPOIL : QS_OPEN;
        end
      end
      QS_OPEN: begin
        if (!low_both) begin
          st_d  = QS_IDLE;
          stb_d = long_enough;
        end else if (inhibit) begin
          st_d = QS_SPOIL;
        end
      end
      QS_SPOIL: begin
        if (!low_both) st_d = QS_IDLE;
      end
      default: st_d = QS_IDLE;
    endcase
    out_en = stb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= QS_IDLE;
      cand_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cand_q <= cand_d;
      stb_q  <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      d_q <= '0;
    end else if (out_en) begin
      a_q <= cand_q;
      d_q <= din;
    end
  end

  assign wr_stb  = stb_q;
  assign wr_addr = a_q;
  assign wr_data = d_q;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R4

  AST_SPOIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == QS_SPOIL) |=> !wr_stb); // R6

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> ($stable(wr_addr) && $stable(wr_data))); // R4

endmodule

// File: rtl/nvm_write_qualifier.sv
`timescale 1ns/1ps
module nvm_write_qualifier #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned MIN_LOW_CYC = 2,
  parameter int unsigned PWR_DLY_CYC = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              supply_ok,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_int_n;
  logic                  low_both;
  logic                  long_enough;
  logic                  write_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end

  assign rst_int_n = rst_pipe[RST_STAGES-1];
  assign low_both  = !cs_n && !we_n;

  nwq_power_lockout #(.PWR_DLY_CYC(PWR_DLY_CYC)) u_lock (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .supply_ok(supply_ok),
    .write_ok (write_ok)
  );

  nwq_low_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_filt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .low_both   (low_both),
    .long_enough(long_enough)
  );

  nwq_cycle_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .low_both   (low_both),
    .oe_n       (oe_n),
    .write_ok   (write_ok),
    .long_enough(long_enough),
    .addr       (addr),
    .din        (din),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  AST_STB_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stb |-> ($past(cs_n || we_n) && $past(!cs_n && !we_n, 2))); // R2

  AST_STB_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stb |-> $past(oe_n, 2)); // R6

  AST_STB_POWERED: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stb |-> $past(write_ok, 2)); // R7

  AST_STB_SUPPLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stb |-> $past(supply_ok, 2)); // R8

endmodule

// File: tb/nvm_write_qualifier_test.sv
`timescale 1ns/1ps
module nvm_write_qualifier_test;

  localparam int AW  = 17;
  localparam int DW  = 16;
  localparam int MIN = 3;
  localparam int DLY = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, we_n, oe_n, supply_ok;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            cyc;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   stb_seen = 0;
  bit   prev_stb = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvm_write_qualifier #(
    .ADDR_W(AW), .DATA_W(DW), .MIN_LOW_CYC(MIN), .PWR_DLY_CYC(DLY)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .supply_ok(supply_ok),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as strobes appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        stb_seen++;
        chk(!prev_stb, "R4", "strobe wider than one cycle", 1, 0);
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected strobe addr", longint'(wr_addr), 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(wr_addr == e.a, "R3", "captured address", longint'(wr_addr), longint'(e.a));
          chk(wr_data == e.d, "R4", "captured data", longint'(wr_data), longint'(e.d));
          chk(cyc == e.cyc, "R4", "strobe cycle", cyc, e.cyc);
        end
      end
      prev_stb = wr_stb;
    end
  end

  // driver: one write-shaped pulse; spoil 1 = oe low, 2 = supply drop
  task automatic pulse(input bit cs_first, input bit cs_rise_first, input int len,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int spoil, input bit expect_ok, input string tag);
    int s0;
    s0 = stb_seen;
    addr = ~a;
    din  = ~d;
    if (cs_first) cs_n = 1'b0; else we_n = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    addr = a;
    if (cs_first) we_n = 1'b0; else cs_n = 1'b0;
    for (int i = 1; i <= len; i++) begin
      @(posedge clk);
      #2;
      if (i == 1) begin
        addr = ~a;
        if (spoil == 1) oe_n = 1'b0;
        if (spoil == 2) supply_ok = 1'b0;
      end
      if (i == 2) begin
        oe_n = 1'b1;
        supply_ok = 1'b1;
      end
      if (i == len) begin
        din = d;
        if (cs_rise_first) cs_n = 1'b1; else we_n = 1'b1;
        if (expect_ok) begin
          exp_t e;
          e.a = a;
          e.d = d;
          e.cyc = cyc + 1;
          sb.push_back(e);
        end
      end
    end
    @(posedge clk);
    #2;
    din  = ~d;
    cs_n = 1'b1;
    we_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    if (expect_ok)
      chk(sb.size() == 0, tag, "accepted write not delivered", sb.size(), 0);
    else
      chk(stb_seen == s0, tag, "rejected pulse produced strobes", stb_seen - s0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; supply_ok = 1'b1;
    addr = '0; din = '0;
    repeat (4) @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk(wr_stb == 1'b0, "R1", "reset strobe", wr_stb, 0);
    chk(wr_addr == '0, "R1", "reset address", wr_addr, 0);
    chk(wr_data == '0, "R1", "reset data", wr_data, 0);
    repeat (DLY + 5) @(posedge clk);
    #2;

    pulse(1, 0, MIN,     17'h15555, 16'hA55A, 0, 1, "R3");
    pulse(0, 1, MIN + 2, 17'h02AAA, 16'h3C3C, 0, 1, "R9");
    pulse(1, 1, MIN + 1, 17'h1FFFF, 16'hFFFF, 0, 1, "R9");
    pulse(0, 0, MIN,     17'h00001, 16'h0001, 0, 1, "R4");
    pulse(1, 0, MIN - 1, 17'h00123, 16'h1234, 0, 0, "R5");
    pulse(0, 1, 1,       17'h00456, 16'h4567, 0, 0, "R5");

    begin : lone_strobe
      int s0;
      s0 = stb_seen;
      we_n = 1'b0;
      repeat (10) @(posedge clk);
      #2;
      we_n = 1'b1;
      cs_n = 1'b0;
      repeat (10) @(posedge clk);
      #2;
      cs_n = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      chk(stb_seen == s0, "R2", "single strobe produced writes", stb_seen - s0, 0);
    end

    oe_n = 1'b0;
    pulse(1, 0, MIN + 2, 17'h00777, 16'h7777, 0, 0, "R6");
    oe_n = 1'b1;
    pulse(1, 0, MIN + 2, 17'h00888, 16'h8888, 1, 0, "R6");
    pulse(0, 0, MIN + 2, 17'h00999, 16'h9999, 0, 1, "R6");

    pulse(1, 1, MIN + 2, 17'h00AAA, 16'hAAAA, 2, 0, "R8");
    pulse(1, 1, MIN + 2, 17'h00BBB, 16'hBBBB, 0, 0, "R7");
    supply_ok = 1'b0;
    repeat (5) @(posedge clk);
    #2;
    pulse(0, 1, MIN + 2, 17'h00CCC, 16'hCCCC, 0, 0, "R7");
    supply_ok = 1'b1;
    repeat (DLY + 5) @(posedge clk);
    #2;
    pulse(0, 1, MIN + 2, 17'h00DDD, 16'hDDDD, 0, 1, "R7");

    repeat (5) @(posedge clk);
    #2;
    chk(sb.size() == 0, "R2", "scoreboard leftovers", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule